// File: doc/BRIEF.md
# Multi-Register Compare-Match Output Unit

This block holds one free-running up-counter and a set of compare slots. Each slot has a compare value, a two-bit output mode, a status flag, an interrupt enable and one output pin. The counter advances by one on every clock where the run bit is set and the clock-enable input `tick` is high. When the counter reaches a slot's compare value, that slot can raise its flag and act on its pin. Depending on the mode, the pin is forced low, forced high or toggled. The counter keeps running through a match and wraps at its top value.

Software configures the block through a simple single-cycle write port with a combinational read path. The combined interrupt line is the OR, taken over every slot, of the slot's flag ANDed with its enable.

Top module: `cmo_unit`

## Requirements
- R1: After reset, all of the following are zero: the counter, the run bit, every flag, every enable, every mode field, every compare value, every pin and `irq`.
- R2: On a clock edge with run=1 and tick=1 and no counter write, the counter increases by one. In every other case with no counter write, it holds its value.
- R3: The counter wraps from 0xFFFF to 0x0000 and does not clear on a match.
- R4: A slot hits when all of the following hold on a clock edge: run=1, tick=1, the counter equals the slot's compare value, and its mode is not 00. On that edge, the slot's flag becomes 1.
- R5: On a hit, the pin takes its new value on the same edge, so it is visible in the following cycle. Mode 01 drives the pin to 0, mode 10 drives it to 1, and mode 11 inverts it.
- R6: A slot in mode 00 never sets its flag and never changes its pin, even when its compare value equals the counter.
- R7: `irq` is 1 exactly when at least one slot has both its flag and its enable set.
- R8: Writing to the flag register clears every flag whose bit in `wdata` is 1. Flags whose bit is 0 are unaffected. If a hit on a slot falls on the same edge as a clear of that slot's flag, the flag stays 1.
- R9: A write to the counter address loads `wdata` into the counter. This load takes precedence over an increment on the same edge.
- R10: The register map is as follows:
  - Address 0, bit 0: the run bit.
  - Address 1: the counter.
  - Address 2: the flags, one bit per slot.
  - Address 3: the enables, one bit per slot.
  - Address 4: the mode fields. Slot i uses bits 2i+1:2i.
  - Address 8+i: compare value i.
  - All other addresses read 0.
  - `rdata` reflects `addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Counter clock enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| pins | output | 8 | Compare output pins, one per slot |
| irq | output | 1 | Combined interrupt request |

## Verification
Two events can land on the same edge: a slot's flag being cleared by software, and a new hit on that same slot. The bench provokes this by loading the counter with the compare value, then driving a flag-register write with that bit set in the very cycle where `tick` is high. It judges the result by reading the flag back afterwards and expecting 1, with `irq` still high. A second overlap is a counter write arriving together with a counting tick. For that case the bench expects the written value, not the incremented one.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_t;

  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_COUNT = 1;
  localparam int unsigned REG_FLAG  = 2;
  localparam int unsigned REG_IEN   = 3;
  localparam int unsigned REG_MODE  = 4;
  localparam int unsigned CMP_BASE  = 8;

  function automatic logic pin_after_hit(act_t act, logic cur);
    case (act)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  function automatic logic slot_hits(logic step, logic equal, act_t act);
    return step && equal && (act != ACT_NONE);
  endfunction
endpackage

// File: rtl/cmo_counter.sv
module cmo_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (step)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cmo_slot.sv
module cmo_slot
  import cmo_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_val,
  input  act_t             act,
  input  logic             flag_clr,
  output logic             hit,
  output logic             flag,
  output logic             pin
);
  logic equal;
  assign equal = (cnt == cmp_val);
  assign hit   = slot_hits(step, equal, act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pin <= 1'b0;
    else if (hit) pin <= pin_after_hit(act, pin);
  end
endmodule

// File: rtl/cmo_unit.sv
module cmo_unit
  import cmo_pkg::*;
#(
  parameter int unsigned NUM_CMP = 8,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   rdata,
  output logic [NUM_CMP-1:0] pins,
  output logic               irq
);
  localparam int unsigned MODE_W = 2 * NUM_CMP;

  logic               run;
  logic [CNT_W-1:0]   cnt;
  logic               step;
  logic               cnt_ld;
  logic [NUM_CMP-1:0] ien;
  logic [MODE_W-1:0]  mode_reg;
  logic [CNT_W-1:0]   cmp_q [NUM_CMP];
  logic [NUM_CMP-1:0] hit;
  logic [NUM_CMP-1:0] flags;
  logic [NUM_CMP-1:0] flag_clr;

  assign step     = run && tick;
  assign cnt_ld   = wr_en && (addr == ADDR_W'(REG_COUNT));
  assign flag_clr = (wr_en && (addr == ADDR_W'(REG_FLAG))) ? wdata[NUM_CMP-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      ien      <= '0;
      mode_reg <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(REG_CTRL)) run      <= wdata[0];
      if (addr == ADDR_W'(REG_IEN))  ien      <= wdata[NUM_CMP-1:0];
      if (addr == ADDR_W'(REG_MODE)) mode_reg <= wdata[MODE_W-1:0];
    end
  end

  cmo_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .load(cnt_ld),
    .load_val(wdata), .cnt(cnt)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
    logic cmp_we;
    assign cmp_we = wr_en && (addr == ADDR_W'(CMP_BASE + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q[i] <= '0;
      else if (cmp_we) cmp_q[i] <= wdata;
    end

    cmo_slot #(.CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .step(step), .cnt(cnt),
      .cmp_val(cmp_q[i]), .act(act_t'(mode_reg[2*i +: 2])),
      .flag_clr(flag_clr[i]), .hit(hit[i]), .flag(flags[i]), .pin(pins[i])
    );
  end

  assign irq = |(flags & ien);

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(REG_CTRL))       rdata[0] = run;
    else if (addr == ADDR_W'(REG_COUNT)) rdata = cnt;
    else if (addr == ADDR_W'(REG_FLAG))  rdata[NUM_CMP-1:0] = flags;
    else if (addr == ADDR_W'(REG_IEN))   rdata[NUM_CMP-1:0] = ien;
    else if (addr == ADDR_W'(REG_MODE))  rdata[MODE_W-1:0] = mode_reg;
    else begin
      for (int k = 0; k < NUM_CMP; k++)
        if (addr == ADDR_W'(CMP_BASE + k)) rdata = cmp_q[k];
    end
  end
endmodule

// File: rtl/cmo_checker.sv
module cmo_checker #(
  parameter int unsigned NUM_CMP = 8,
  parameter int unsigned CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               step,
  input logic               cnt_ld,
  input logic [CNT_W-1:0]   cnt,
  input logic [NUM_CMP-1:0] hit,
  input logic [NUM_CMP-1:0] flags,
  input logic [NUM_CMP-1:0] ien,
  input logic [NUM_CMP-1:0] pins,
  input logic               irq
);
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_ld) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !cnt_ld) |=> $stable(cnt));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_ld && (cnt == '1)) |=> (cnt == '0));

  a_r4_flag_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((flags & $past(hit)) == $past(hit)));

  a_r6_pins_move_on_hit_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((pins ^ $past(pins)) & ~$past(hit)) == '0);

  a_r7_irq_combine: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(flags & ien));

  a_r8_flag_rise_on_hit_only: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~$past(flags) & ~$past(hit)) == '0);
endmodule

bind cmo_unit cmo_checker #(.NUM_CMP(NUM_CMP), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .cnt_ld(cnt_ld), .cnt(cnt),
  .hit(hit), .flags(flags), .ien(ien), .pins(pins), .irq(irq)
);

// File: tb/cmo_unit_tb.sv
`timescale 1ns/100ps
module cmo_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  pins;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cmo_unit dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pins(pins), .irq(irq)
  );

  typedef struct packed {
    logic [2:0]  slot;
    logic [1:0]  mode;
    logic [15:0] cmpv;
    logic [15:0] cnt0;
    logic [7:0]  steps;
    logic        eflag;
    logic        epin;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'b10, 16'h0005, 16'h0003, 8'd4, 1'b1, 1'b1},
    '{3'd1, 2'b01, 16'h0005, 16'h0003, 8'd4, 1'b1, 1'b0},
    '{3'd2, 2'b11, 16'h0001, 16'hFFFE, 8'd4, 1'b1, 1'b1},
    '{3'd3, 2'b00, 16'h0005, 16'h0003, 8'd4, 1'b0, 1'b0},
    '{3'd7, 2'b10, 16'h000A, 16'h0003, 8'd4, 1'b0, 1'b0},
    '{3'd4, 2'b11, 16'h0003, 16'h0003, 8'd1, 1'b1, 1'b1}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic step_n(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog R1..R10 not finished: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    do_reset();

    // R1 reset state
    rd(4'd0, v);  check("R1 run", v, 0);
    rd(4'd1, v);  check("R1 count", v, 0);
    rd(4'd2, v);  check("R1 flags", v, 0);
    rd(4'd4, v);  check("R1 modes", v, 0);
    rd(4'd9, v);  check("R1 cmp1", v, 0);
    check("R1 pins", pins, 0);
    check("R1 irq", irq, 0);

    // Table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      vec_t t = VECS[i];
      logic [15:0] fl;
      do_reset();
      wr(4'd0, 16'h0001);
      wr(4'd3, 16'h00FF);
      wr(4'd4, 16'(t.mode) << (2 * t.slot));
      wr(4'd8 + 4'(t.slot), t.cmpv);
      wr(4'd1, t.cnt0);
      step_n(int'(t.steps));
      rd(4'd2, fl);
      check($sformatf("R4 R6 vec%0d flag", i), fl[t.slot], t.eflag);
      check($sformatf("R5 R6 vec%0d pin", i), pins[t.slot], t.epin);
      check($sformatf("R7 vec%0d irq", i), irq, t.eflag);
      rd(4'd1, v);
      check($sformatf("R2 R3 vec%0d count", i), v, 16'(t.cnt0 + 16'(t.steps)));
    end

    // R2 hold when tick low, and when run low
    do_reset();
    wr(4'd0, 16'h0001);
    wr(4'd1, 16'h0040);
    repeat (3) @(negedge clk);
    rd(4'd1, v); check("R2 hold tick low", v, 16'h0040);
    wr(4'd0, 16'h0000);
    step_n(3);
    rd(4'd1, v); check("R2 hold run low", v, 16'h0040);

    // R5 sequence on slot 0: toggle twice, then set, then clear
    do_reset();
    wr(4'd0, 16'h0001);
    wr(4'd4, 16'h0003);
    wr(4'd8, 16'h0010);
    wr(4'd1, 16'h0010); step_n(1);
    check("R5 toggle 1", pins[0], 1);
    wr(4'd1, 16'h0010); step_n(1);
    check("R5 toggle 2", pins[0], 0);
    wr(4'd4, 16'h0002);
    wr(4'd1, 16'h0010); step_n(1);
    check("R5 force high", pins[0], 1);
    // R6: mode 00 keeps pin and flag untouched
    wr(4'd2, 16'h0001);
    wr(4'd4, 16'h0000);
    wr(4'd1, 16'h0010); step_n(1);
    check("R6 pin kept", pins[0], 1);
    rd(4'd2, v); check("R6 no flag", v, 0);
    wr(4'd4, 16'h0001);
    wr(4'd1, 16'h0010); step_n(1);
    check("R5 force low", pins[0], 0);

    // R7 enable gating
    check("R7 irq masked", irq, 0);
    wr(4'd3, 16'h0001);
    check("R7 irq enabled", irq, 1);

    // R8 collision: clear and hit on the same edge
    wr(4'd1, 16'h0010);
    wr_en = 1'b1; addr = 4'd2; wdata = 16'h0001; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    rd(4'd2, v); check("R8 hit beats clear", v, 16'h0001);
    check("R8 irq kept", irq, 1);
    wr(4'd2, 16'h0000);
    rd(4'd2, v); check("R8 zero bit no effect", v, 16'h0001);
    wr(4'd2, 16'h0001);
    rd(4'd2, v); check("R8 w1c", v, 0);
    check("R8 irq cleared", irq, 0);

    // R9 counter write beats increment
    wr(4'd1, 16'h0100);
    wr_en = 1'b1; addr = 4'd1; wdata = 16'h0200; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    rd(4'd1, v); check("R9 load wins", v, 16'h0200);

    // R10 readback
    wr(4'd10, 16'h1234);
    rd(4'd10, v); check("R10 cmp2", v, 16'h1234);
    wr(4'd4, 16'hC6A5);
    rd(4'd4, v); check("R10 modes", v, 16'hC6A5);
    rd(4'd5, v); check("R10 unused", v, 0);
    rd(4'd0, v); check("R10 run", v, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule